// File: doc/BRIEF.md
# Video shift-register load sequencer

This block is the glue between a graphics processor and a video DRAM controller. It decides when the video DRAMs copy one row into their serial shift registers during a screen-refresh access. The processor announces that access with its address-latch-enable and two bus-status bits. The block remembers that access in a refresh latch. A display-refresh request arms a down-counter with a programmable delay. The counter runs only while the refresh latch holds. When it expires, the block fires a one-clock load strobe.

While the access is open and the delay has not run out, the block holds the processor's WAIT line low to insert wait states. It also holds the DRAM transfer/output-enable line low. Both lines are released on the same clock edge where the load strobe rises. The block is clocked by the processor clock, which has a nominal 50 ns period.

Top module: `vsl_load_sequencer`

## Requirements
- R1: While `rst` is sampled high, the next clock leaves `load_stb` at 0 and both `wait_n` and `dt_oe_n` at 1.
- R2: A clock edge that samples `ale`=1 with `bst` = 2'b11 (screen refresh) sets the refresh latch. If the counter holds a nonzero count, `wait_n` reads 0 after that edge.
- R3: A clock edge that samples `bst` other than 2'b11 clears the refresh latch. `wait_n` and `dt_oe_n` then read 1 after that edge, even with counts left, and no strobe follows.
- R4: A clock edge that samples `rfsh_req`=1 loads the counter with `DELAY`. The counter decrements only on edges where the refresh latch is set. While the latch is clear, the count is frozen.
- R5: `load_stb` is 1 for exactly one clock. It rises on the edge where the latch is set and the count steps from 1 to 0. With the latch set and the request taken on the same edge, that is `DELAY` edges later.
- R6: `wait_n` is 0 exactly while the refresh latch is set and the count is nonzero.
- R7: `dt_oe_n` follows the same condition as `wait_n`. It returns to 1 on the same edge where `load_stb` rises.
- R8: The terminal count clears the refresh latch even while `bst` stays 2'b11. No second strobe follows without a new `ale`.
- R9: A request sampled while a count is in progress restarts the delay from `DELAY`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous reset, active high |
| ale | input | 1 | Address-latch-enable from the processor |
| bst | input | 2 | Bus-status bits; 2'b11 marks a screen-refresh access |
| rfsh_req | input | 1 | Display-refresh request; arms the load delay |
| load_stb | output | 1 | One-clock shift-register load strobe |
| wait_n | output | 1 | Processor WAIT, active low |
| dt_oe_n | output | 1 | DRAM transfer/output-enable, active low |

## Verification
Directed runs cover four cases:
- The request and the latch arriving together, which pins the strobe at exactly `DELAY` edges.
- A request made before the latch, which shows that the count freezes.
- A status change partway through, which separates clearing the latch from letting the counter expire.
- A second request partway through, which shows the delay restarting rather than continuing.

Random runs weight the status toward screen refresh and keep requests sparse. This lets strobes, aborts and overlapping requests mix freely. Every clock is compared with a bench model of the requirements.

// File: rtl/vsl_pkg.sv
package vsl_pkg;
   typedef logic [1:0] bus_status_t;
   localparam bus_status_t ST_SCREEN_REFRESH = 2'b11;

   function automatic logic is_refresh(input bus_status_t s);
      return s == ST_SCREEN_REFRESH;
   endfunction
endpackage

// File: rtl/vsl_refresh_latch.sv
module vsl_refresh_latch
   import vsl_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  logic        ale,
   input  bus_status_t bst,
   input  logic        term,
   output logic        rf_q
);
   logic rf_d;

   always_comb begin
      rf_d = is_refresh(bst) & (ale | rf_q) & ~term;
   end

   always_ff @(posedge clk) begin
      if (rst) rf_q <= 1'b0;
      else     rf_q <= rf_d;
   end
endmodule

// File: rtl/vsl_load_counter.sv
module vsl_load_counter #(
   parameter int DELAY = 4,
   localparam int CW   = (DELAY < 2) ? 1 : $clog2(DELAY + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic          run,
   output logic [CW-1:0] cnt_q,
   output logic          not_done,
   output logic          term
);
   localparam logic [CW-1:0] LOAD_VAL = CW'(DELAY);
   localparam logic [CW-1:0] ONE      = CW'(1);

   generate
      if (DELAY == 1) begin : g_flag
         always_ff @(posedge clk) begin
            if (rst)       cnt_q <= '0;
            else if (load) cnt_q <= ONE;
            else if (run)  cnt_q <= '0;
         end
      end else begin : g_down
         always_ff @(posedge clk) begin
            if (rst)                        cnt_q <= '0;
            else if (load)                  cnt_q <= LOAD_VAL;
            else if (run && cnt_q != '0)    cnt_q <= cnt_q - ONE;
         end
      end
   endgenerate

   assign not_done = (cnt_q != '0);
   assign term     = run & (cnt_q == ONE);
endmodule

// File: rtl/vsl_handshake_out.sv
module vsl_handshake_out (
   input  logic clk,
   input  logic rst,
   input  logic rf_q,
   input  logic not_done,
   input  logic term,
   output logic load_stb,
   output logic wait_n,
   output logic dt_oe_n
);
   logic pending;

   always_ff @(posedge clk) begin
      if (rst) load_stb <= 1'b0;
      else     load_stb <= term;
   end

   always_comb begin
      pending = rf_q & not_done;
      wait_n  = ~pending;
      dt_oe_n = ~pending;
   end
endmodule

// File: rtl/vsl_load_sequencer.sv
module vsl_load_sequencer
   import vsl_pkg::*;
#(
   parameter int DELAY = 4,
   localparam int CW   = (DELAY < 2) ? 1 : $clog2(DELAY + 1)
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       ale,
   input  logic [1:0] bst,
   input  logic       rfsh_req,
   output logic       load_stb,
   output logic       wait_n,
   output logic       dt_oe_n
);
   generate
      if (DELAY < 1) begin : g_bad_delay
         $error("vsl_load_sequencer: DELAY must be at least 1");
      end
      if (DELAY > 65535) begin : g_big_delay
         $error("vsl_load_sequencer: DELAY exceeds supported range");
      end
   endgenerate

   logic          rf_q;
   logic          term;
   logic          not_done;
   logic [CW-1:0] cnt_q;

   vsl_refresh_latch u_latch (
      .clk  (clk),
      .rst  (rst),
      .ale  (ale),
      .bst  (bst),
      .term (term),
      .rf_q (rf_q)
   );

   vsl_load_counter #(.DELAY(DELAY)) u_count (
      .clk      (clk),
      .rst      (rst),
      .load     (rfsh_req),
      .run      (rf_q),
      .cnt_q    (cnt_q),
      .not_done (not_done),
      .term     (term)
   );

   vsl_handshake_out u_out (
      .clk      (clk),
      .rst      (rst),
      .rf_q     (rf_q),
      .not_done (not_done),
      .term     (term),
      .load_stb (load_stb),
      .wait_n   (wait_n),
      .dt_oe_n  (dt_oe_n)
   );
endmodule

// File: rtl/vsl_load_sequencer_chk.sv
module vsl_load_sequencer_chk #(
   parameter int CW = 3
) (
   input logic          clk,
   input logic          rst,
   input logic          ale,
   input logic [1:0]    bst,
   input logic          rfsh_req,
   input logic          load_stb,
   input logic          wait_n,
   input logic          dt_oe_n,
   input logic          rf_q,
   input logic [CW-1:0] cnt_q
);
   assert_reset_idle_R1: assert property (@(posedge clk)
      rst |=> (!load_stb && wait_n && dt_oe_n));

   assert_latch_set_R2: assert property (@(posedge clk) disable iff (rst)
      (ale && bst == 2'b11 && !rf_q) |=> rf_q);

   assert_latch_clear_R3: assert property (@(posedge clk) disable iff (rst)
      (bst != 2'b11) |=> (!rf_q && wait_n));

   assert_count_frozen_R4: assert property (@(posedge clk) disable iff (rst)
      (!rf_q && !rfsh_req) |=> $stable(cnt_q));

   assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
      load_stb |=> !load_stb);

   assert_wait_needs_latch_R6: assert property (@(posedge clk) disable iff (rst)
      !wait_n |-> (rf_q && cnt_q != '0));

   assert_oe_release_R7: assert property (@(posedge clk) disable iff (rst)
      $rose(load_stb) |-> (dt_oe_n && wait_n));

   assert_term_clears_R8: assert property (@(posedge clk) disable iff (rst)
      load_stb |-> !rf_q);
endmodule

bind vsl_load_sequencer vsl_load_sequencer_chk #(.CW(CW)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .ale      (ale),
   .bst      (bst),
   .rfsh_req (rfsh_req),
   .load_stb (load_stb),
   .wait_n   (wait_n),
   .dt_oe_n  (dt_oe_n),
   .rf_q     (rf_q),
   .cnt_q    (cnt_q)
);

// File: tb/vsl_load_sequencer_tb.sv
module vsl_load_sequencer_tb_top;
   localparam int CLK_PERIOD = 50;
   localparam int DLY        = 4;
   localparam int WATCHDOG   = 50000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ale = 1'b0;
   logic [1:0] bst = 2'b00;
   logic       rfsh_req = 1'b0;
   logic       load_stb, wait_n, dt_oe_n;

   int n_vec  = 0;
   int n_fail = 0;
   bit done   = 0;

   // bench model state
   bit m_rf  = 0;
   int m_cnt = 0;
   bit m_stb = 0;

   vsl_load_sequencer #(.DELAY(DLY)) dut_i (
      .clk(clk), .rst(rst), .ale(ale), .bst(bst), .rfsh_req(rfsh_req),
      .load_stb(load_stb), .wait_n(wait_n), .dt_oe_n(dt_oe_n)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic bit exp_wait_n();
      return !(m_rf && m_cnt != 0);
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // advance the model by one edge using the currently driven inputs
   task automatic model_step();
      bit term;
      if (rst) begin
         m_rf = 0; m_cnt = 0; m_stb = 0;
      end else begin
         term  = m_rf && (m_cnt == 1);
         m_stb = term;
         if (rfsh_req)                m_cnt = DLY;
         else if (m_rf && m_cnt != 0) m_cnt = m_cnt - 1;
         m_rf  = (bst == 2'b11) && (ale || m_rf) && !term;
      end
   endtask

   task automatic cycle(input bit a, input logic [1:0] s, input bit q);
      ale = a; bst = s; rfsh_req = q;
      @(posedge clk);
      model_step();
      @(negedge clk);
      chk("R5", "load_stb vs model", load_stb, m_stb);
      chk("R6", "wait_n vs model", wait_n, exp_wait_n());
      chk("R7", "dt_oe_n vs model", dt_oe_n, exp_wait_n());
   endtask

   task automatic do_reset();
      rst = 1'b1;
      cycle(0, 2'b00, 0);
      rst = 1'b0;
   endtask

   initial begin
      int seed;
      seed = 32'h5eed_0042;
      void'($urandom(seed));
      @(negedge clk);

      // R1: reset state
      do_reset();
      chk("R1", "load_stb after reset", load_stb, 0);
      chk("R1", "wait_n after reset", wait_n, 1);
      chk("R1", "dt_oe_n after reset", dt_oe_n, 1);

      // R2/R5/R7/R8: latch and request together
      cycle(1, 2'b11, 1);
      chk("R2", "wait_n after set", wait_n, 0);
      for (int i = 1; i < DLY; i++) begin
         cycle(0, 2'b11, 0);
         chk("R5", "no early strobe", load_stb, 0);
      end
      cycle(0, 2'b11, 0);
      chk("R5", "strobe at DELAY", load_stb, 1);
      chk("R7", "dt_oe_n released with strobe", dt_oe_n, 1);
      cycle(0, 2'b11, 0);
      chk("R5", "strobe one clock", load_stb, 0);
      chk("R8", "wait_n stays released", wait_n, 1);
      for (int i = 0; i < DLY + 2; i++) begin
         cycle(0, 2'b11, 0);
         chk("R8", "no second strobe", load_stb, 0);
      end

      // R4: request before latch, count frozen
      do_reset();
      cycle(0, 2'b01, 1);
      for (int i = 0; i < 3 * DLY; i++) cycle(0, 2'b10, 0);
      cycle(1, 2'b11, 0);
      chk("R4", "wait_n low after late set", wait_n, 0);
      for (int i = 1; i < DLY; i++) cycle(0, 2'b11, 0);
      chk("R4", "no strobe before DELAY running edges", load_stb, 0);
      cycle(0, 2'b11, 0);
      chk("R4", "strobe after frozen count", load_stb, 1);

      // R3: status change aborts
      do_reset();
      cycle(1, 2'b11, 1);
      cycle(0, 2'b11, 0);
      cycle(0, 2'b01, 0);
      chk("R3", "wait_n released on abort", wait_n, 1);
      chk("R3", "dt_oe_n released on abort", dt_oe_n, 1);
      for (int i = 0; i < DLY + 2; i++) begin
         cycle(0, 2'b11, 0);
         chk("R3", "no strobe after abort", load_stb, 0);
      end

      // R9: second request restarts the delay
      do_reset();
      cycle(1, 2'b11, 1);
      cycle(0, 2'b11, 0);
      cycle(0, 2'b11, 1);
      for (int i = 1; i < DLY; i++) begin
         cycle(0, 2'b11, 0);
         chk("R9", "no strobe before restarted delay", load_stb, 0);
      end
      cycle(0, 2'b11, 0);
      chk("R9", "strobe after restarted delay", load_stb, 1);

      // random mix, compared each clock with the model
      do_reset();
      for (int i = 0; i < 3000; i++) begin
         bit a, q;
         logic [1:0] s;
         a = ($urandom % 4) == 0;
         s = (($urandom % 8) < 6) ? 2'b11 : 2'($urandom % 3);
         q = ($urandom % 9) == 0;
         cycle(a, s, q);
      end

      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end
endmodule